// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the interrupt sources of a memory-mapped serial port into one sticky status word, gates that word with a software enable mask, and raises a single registered, active-high interrupt line. The receive and transmit buffers report into it through plain wires. Conditions that last, such as "data waiting" or "transmitter empty", arrive as levels. Conditions that happen once, such as "almost full", "timeout", "overrun" or "almost empty", arrive as one-cycle pulses. The clear-to-send input is asynchronous; the block synchronises it and latches every change.

Software reaches the block through a 32-bit word-addressed register port with four words: status, enable, pending and control. Status flags are cleared by writing ones. The pending word is the masked view that explains the interrupt. The control word issues one-cycle flush strobes to the receive and transmit buffers, sets the request-to-send output, and shows the synchronised clear-to-send level. A transmit flush also drops the transmit-full flag, so a driver that flushes need not clear that flag itself.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, status, enable and pending read 0, and irq_o, rts_o, rx_flush_o and tx_flush_o are low.
- R2: Writing the status word (byte offset 0x0) clears each flag whose data bit is 1 and leaves the others unchanged, so writing 0x1FF clears all nine flags. Flag bits: 0 rx data waiting, 1 rx almost full, 2 rx full, 3 rx timeout, 4 rx overrun, 5 tx full, 6 tx almost empty, 7 tx empty, 8 CTS change.
- R3: Level flags (bits 0, 2, 5, 7) are set in every cycle their input is high and stay latched after it drops. A clear wins in its own cycle, and the flag is set again on the next cycle if the input is still high.
- R4: Event flags (bits 1, 3, 4, 6, 8) are set by a pulse and then hold until cleared. A pulse in the same cycle as a clear leaves the flag set. A cleared flag stays clear until a new event arrives.
- R5: A change of cts_i sets status bit 8 within SYNC_STAGES+2 clock cycles. Control bit 3 reads the synchronised CTS level.
- R6: The enable word (offset 0x4) holds nine bits. The pending word (offset 0x8, read-only) reads status AND enable, so it reads 0 whenever enable is 0.
- R7: irq_o is registered: one cycle after any change, it equals the OR of the pending bits.
- R8: A control write (offset 0xC) with bit 0 set gives a one-cycle rx_flush_o pulse in the following cycle. Bit 1 does the same on tx_flush_o. Both bits read back as 0.
- R9: A control write with bit 1 set clears status bit 5 (tx full) in the same cycle as the write.
- R10: rts_o and control bit 2 follow bit 2 of the most recent control write.
- R11: Address bits [1:0] are ignored for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| rx_avail_i | input | 1 | Level: receive data waiting |
| rx_afull_evt_i | input | 1 | Pulse: receive buffer reached almost full |
| rx_full_i | input | 1 | Level: receive buffer full |
| rx_tmo_evt_i | input | 1 | Pulse: receive timeout |
| rx_ovr_evt_i | input | 1 | Pulse: receive overrun |
| tx_full_i | input | 1 | Level: transmit buffer full |
| tx_aempty_evt_i | input | 1 | Pulse: transmit buffer reached almost empty |
| tx_empty_i | input | 1 | Level: transmit buffer empty |
| cts_i | input | 1 | Asynchronous clear-to-send input |
| irq_o | output | 1 | Registered interrupt request |
| rts_o | output | 1 | Request-to-send output |
| rx_flush_o | output | 1 | One-cycle receive flush strobe |
| tx_flush_o | output | 1 | One-cycle transmit flush strobe |

## Verification
The bench builds the block with its defaults: DATA_W=32, ADDR_W=4 and SYNC_STAGES=2. With nine flags, the whole enable space is only 512 values. This lets the bench sweep every enable mask against several status patterns and compute the expected pending word and interrupt as a bitwise AND. The two-stage synchroniser fixes the CTS latency to a few cycles, and every flag position can be cleared on its own in turn.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
   localparam int NFLAG = 9;

   localparam int F_RX_AVAIL  = 0;
   localparam int F_RX_AFULL  = 1;
   localparam int F_RX_FULL   = 2;
   localparam int F_RX_TMO    = 3;
   localparam int F_RX_OVR    = 4;
   localparam int F_TX_FULL   = 5;
   localparam int F_TX_AEMPTY = 6;
   localparam int F_TX_EMPTY  = 7;
   localparam int F_CTS_CHG   = 8;

   // 1 = level-type flag, 0 = event-type flag
   localparam logic [NFLAG-1:0] LEVEL_KIND =
      NFLAG'((1 << F_RX_AVAIL) | (1 << F_RX_FULL) | (1 << F_TX_FULL) | (1 << F_TX_EMPTY));

   localparam int W_STAT = 0;
   localparam int W_ENA  = 1;
   localparam int W_PEND = 2;
   localparam int W_CTRL = 3;

   localparam int CB_FLUSH_RX = 0;
   localparam int CB_FLUSH_TX = 1;
   localparam int CB_RTS      = 2;
   localparam int CB_CTS      = 3;
   localparam int CB_W        = 4;
endpackage

// File: rtl/uirq_sync.sv
`timescale 1ns/1ps
module uirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic toggle_o
);
   logic prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("uirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], async_i};
         prev_q  <= shift_q[STAGES-1];
      end
   end

   assign level_o  = shift_q[STAGES-1];
   assign toggle_o = level_o ^ prev_q;

   // R5
   cts_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_o) |-> toggle_o);
endmodule

// File: rtl/uirq_flags.sv
`timescale 1ns/1ps
module uirq_flags #(
   parameter int               NFLAG      = 9,
   parameter logic [NFLAG-1:0] LEVEL_KIND = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] flag_o
);
   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         if (LEVEL_KIND[i]) begin : g_level
            always_ff @(posedge clk) begin
               if (!rst_n)        flag_o[i] <= 1'b0;
               else if (clr_i[i]) flag_o[i] <= 1'b0;
               else if (set_i[i]) flag_o[i] <= 1'b1;
            end

            // R3
            lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
               clr_i[i] |=> !flag_o[i]);
            // R3
            lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (set_i[i] && !clr_i[i]) |=> flag_o[i]);
         end else begin : g_event
            always_ff @(posedge clk) begin
               if (!rst_n)        flag_o[i] <= 1'b0;
               else if (set_i[i]) flag_o[i] <= 1'b1;
               else if (clr_i[i]) flag_o[i] <= 1'b0;
            end

            // R2
            evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
            // R4
            evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
            // R4
            evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
               set_i[i] |=> flag_o[i]);
         end
      end
   endgenerate
endmodule

// File: rtl/uirq_ctl.sv
`timescale 1ns/1ps
module uirq_ctl
   import uirq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [CB_W-2:0] wbits_i,
   output logic            rx_flush_o,
   output logic            tx_flush_o,
   output logic            rts_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_flush_o <= 1'b0;
         tx_flush_o <= 1'b0;
         rts_o      <= 1'b0;
      end else begin
         rx_flush_o <= wr_i & wbits_i[CB_FLUSH_RX];
         tx_flush_o <= wr_i & wbits_i[CB_FLUSH_TX];
         if (wr_i) rts_o <= wbits_i[CB_RTS];
      end
   end

   // R8
   rx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush_o |-> $past(wr_i && wbits_i[CB_FLUSH_RX]));
   // R8
   tx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush_o |-> $past(wr_i && wbits_i[CB_FLUSH_TX]));
   // R10
   rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (rts_o == $past(wbits_i[CB_RTS])));
   // R10
   rts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(rts_o));
endmodule

// File: rtl/uirq_ctrl.sv
`timescale 1ns/1ps
module uirq_ctrl
   import uirq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              rx_avail_i,
   input  logic              rx_afull_evt_i,
   input  logic              rx_full_i,
   input  logic              rx_tmo_evt_i,
   input  logic              rx_ovr_evt_i,
   input  logic              tx_full_i,
   input  logic              tx_aempty_evt_i,
   input  logic              tx_empty_i,
   input  logic              cts_i,
   output logic              irq_o,
   output logic              rts_o,
   output logic              rx_flush_o,
   output logic              tx_flush_o
);
   localparam int WORD_LSB = 2;
   localparam int IDX_W    = ADDR_W - WORD_LSB;

   generate
      if (DATA_W < NFLAG || DATA_W < CB_W) begin : g_bad_data
         $error("uirq_ctrl: DATA_W too narrow for the register fields");
      end
      if (ADDR_W < WORD_LSB + 2) begin : g_bad_addr
         $error("uirq_ctrl: ADDR_W cannot reach four words");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             wr_stat, wr_ena, wr_ctrl;
   logic [NFLAG-1:0] set_vec, clr_vec, flag_q, ena_q, pend;
   logic             cts_lvl, cts_tgl;

   assign idx     = reg_addr_i[ADDR_W-1:WORD_LSB];
   assign wr_stat = reg_wr_i && (idx == IDX_W'(W_STAT));
   assign wr_ena  = reg_wr_i && (idx == IDX_W'(W_ENA));
   assign wr_ctrl = reg_wr_i && (idx == IDX_W'(W_CTRL));

   uirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_i  (cts_i),
      .level_o  (cts_lvl),
      .toggle_o (cts_tgl)
   );

   always_comb begin
      set_vec              = '0;
      set_vec[F_RX_AVAIL]  = rx_avail_i;
      set_vec[F_RX_AFULL]  = rx_afull_evt_i;
      set_vec[F_RX_FULL]   = rx_full_i;
      set_vec[F_RX_TMO]    = rx_tmo_evt_i;
      set_vec[F_RX_OVR]    = rx_ovr_evt_i;
      set_vec[F_TX_FULL]   = tx_full_i;
      set_vec[F_TX_AEMPTY] = tx_aempty_evt_i;
      set_vec[F_TX_EMPTY]  = tx_empty_i;
      set_vec[F_CTS_CHG]   = cts_tgl;
   end

   always_comb begin
      clr_vec = wr_stat ? reg_wdata_i[NFLAG-1:0] : '0;
      if (wr_ctrl && reg_wdata_i[CB_FLUSH_TX]) clr_vec[F_TX_FULL] = 1'b1;
   end

   uirq_flags #(.NFLAG(NFLAG), .LEVEL_KIND(LEVEL_KIND)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flag_o (flag_q)
   );

   uirq_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_ctrl),
      .wbits_i    (reg_wdata_i[CB_W-2:0]),
      .rx_flush_o (rx_flush_o),
      .tx_flush_o (tx_flush_o),
      .rts_o      (rts_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q <= '0;
         irq_o <= 1'b0;
      end else begin
         if (wr_ena) ena_q <= reg_wdata_i[NFLAG-1:0];
         irq_o <= |pend;
      end
   end

   assign pend = flag_q & ena_q;

   always_comb begin
      reg_rdata_o = '0;
      case (idx)
         IDX_W'(W_STAT): reg_rdata_o[NFLAG-1:0] = flag_q;
         IDX_W'(W_ENA):  reg_rdata_o[NFLAG-1:0] = ena_q;
         IDX_W'(W_PEND): reg_rdata_o[NFLAG-1:0] = pend;
         IDX_W'(W_CTRL): begin
            reg_rdata_o[CB_RTS] = rts_o;
            reg_rdata_o[CB_CTS] = cts_lvl;
         end
         default:        reg_rdata_o = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{reg_addr_i[WORD_LSB-1:0], reg_wdata_i[DATA_W-1:NFLAG]};

   // R6
   ena_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ena && reg_wdata_i[NFLAG-1:0] == '0) |=> (pend == '0));
   // R7
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ena && reg_wdata_i[NFLAG-1:0] == '0) |=> ##1 !irq_o);
   // R9
   txf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata_i[CB_FLUSH_TX]) |=> !flag_q[F_TX_FULL]);
   // R7
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(flag_q != '0 && ena_q != '0));
endmodule

// File: tb/sim_uirq_ctrl.sv
`timescale 1ns/1ps
module sim_uirq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic rx_avail = 0, rx_afull = 0, rx_full = 0, rx_tmo = 0, rx_ovr = 0;
   logic tx_full = 0, tx_aempty = 0, tx_empty = 0, cts = 0;
   logic irq, rts, rx_flush, tx_flush;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uirq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .rx_avail_i(rx_avail), .rx_afull_evt_i(rx_afull), .rx_full_i(rx_full),
      .rx_tmo_evt_i(rx_tmo), .rx_ovr_evt_i(rx_ovr), .tx_full_i(tx_full),
      .tx_aempty_evt_i(tx_aempty), .tx_empty_i(tx_empty), .cts_i(cts),
      .irq_o(irq), .rts_o(rts), .rx_flush_o(rx_flush), .tx_flush_o(tx_flush)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_all();
      @(negedge clk);
      rx_avail = 1; rx_afull = 1; rx_full = 1; rx_tmo = 1; rx_ovr = 1;
      tx_full = 1; tx_aempty = 1; tx_empty = 1; cts = ~cts;
      @(negedge clk);
      rx_avail = 0; rx_afull = 0; rx_full = 0; rx_tmo = 0; rx_ovr = 0;
      tx_full = 0; tx_aempty = 0; tx_empty = 0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #750000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [8:0]  pats [3];
      logic        prev_irq;
      pats[0] = 9'h1FF; pats[1] = 9'h0A5; pats[2] = 9'h15A;

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(4'h0, d); chk("R1 status", d, 0);
      rd(4'h4, d); chk("R1 enable", d, 0);
      rd(4'h8, d); chk("R1 pending", d, 0);
      chk("R1 outputs", {28'd0, irq, rts, rx_flush, tx_flush}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      // R2 / R4 / R5: all flags latch, then single-bit clears
      set_all();
      rd(4'h0, d); chk("R2 all set", d, 32'h1FF);
      wr(4'h0, 32'h1FF);
      rd(4'h0, d); chk("R2 clear all", d, 0);
      for (int i = 0; i < 9; i++) begin
         set_all();
         wr(4'h0, 32'(1 << i));
         rd(4'h0, d); chk($sformatf("R2 clear bit %0d", i), d, 32'h1FF & ~32'(1 << i));
         wr(4'h0, 32'h1FF);
      end

      // R3 level flag re-asserts while input held
      @(negedge clk); rx_avail = 1;
      wr(4'h0, 32'h001);
      rd(4'h0, d); chk("R3 cleared in write cycle", d, 0);
      @(negedge clk);
      rd(4'h0, d); chk("R3 re-asserted", d, 32'h001);
      rx_avail = 0;
      wr(4'h0, 32'h001);
      repeat (2) @(negedge clk);
      rd(4'h0, d); chk("R3 latch released", d, 0);

      // R4 event in same cycle as clear wins; cleared event stays clear
      @(negedge clk);
      rx_tmo = 1; reg_wr = 1; reg_addr = 4'h0; reg_wdata = 32'h008;
      @(negedge clk);
      rx_tmo = 0; reg_wr = 0;
      rd(4'h0, d); chk("R4 event beats clear", d, 32'h008);
      wr(4'h0, 32'h008);
      repeat (3) @(negedge clk);
      rd(4'h0, d); chk("R4 stays clear", d, 0);

      // R5 CTS change and level
      @(negedge clk); cts = ~cts;
      repeat (4) @(negedge clk);
      rd(4'h0, d); chk("R5 cts change flag", d, 32'h100);
      rd(4'hC, d); chk("R5 cts level", d & 32'h8, {28'd0, cts, 3'd0});
      wr(4'h0, 32'h100);
      repeat (4) @(negedge clk);
      rd(4'h0, d); chk("R5 no change no flag", d, 0);

      // R6 / R7 sweep every enable mask against status patterns
      prev_irq = 1'b0;
      for (int p = 0; p < 3; p++) begin
         set_all();
         wr(4'h0, 32'(~pats[p] & 9'h1FF));
         rd(4'h0, d); chk("R2 pattern", d, 32'(pats[p]));
         @(negedge clk);
         prev_irq = irq;
         for (int e = 0; e < 512; e++) begin
            wr(4'h4, 32'(e));
            rd(4'h8, d); chk("R6 pending", d, 32'(pats[p] & 9'(e)));
            chk("R7 irq lag", {31'd0, irq}, {31'd0, prev_irq});
            @(negedge clk);
            chk("R7 irq", {31'd0, irq}, {31'd0, (pats[p] & 9'(e)) != 0});
            prev_irq = irq;
         end
         wr(4'h0, 32'h1FF);
      end
      wr(4'h4, 0);
      rd(4'h8, d); chk("R6 enable zero", d, 0);

      // R8 flush strobes
      wr(4'hC, 32'h1);
      chk("R8 rx flush pulse", {30'd0, rx_flush, tx_flush}, 32'h2);
      @(negedge clk);
      chk("R8 rx flush ends", {30'd0, rx_flush, tx_flush}, 0);
      wr(4'hC, 32'h2);
      chk("R8 tx flush pulse", {30'd0, rx_flush, tx_flush}, 32'h1);
      @(negedge clk);
      chk("R8 tx flush ends", {30'd0, rx_flush, tx_flush}, 0);
      rd(4'hC, d); chk("R8 flush bits read 0", d & 32'h3, 0);

      // R9 tx flush clears tx-full flag
      set_all();
      wr(4'hC, 32'h2);
      rd(4'h0, d); chk("R9 tx full cleared", d, 32'h1DF);
      wr(4'h0, 32'h1FF);

      // R10 RTS
      wr(4'hC, 32'h4);
      rd(4'hC, d); chk("R10 rts set", {d[2], 30'd0, rts}, 32'h80000001);
      wr(4'hC, 32'h1);
      rd(4'hC, d); chk("R10 rts cleared", {d[2], 30'd0, rts}, 0);

      // R11 low address bits ignored
      wr(4'h7, 32'h3);
      rd(4'h5, d); chk("R11 enable alias", d, 32'h3);
      wr(4'h3, 32'h1FF);
      rd(4'hA, d); chk("R11 pending alias", d, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule